// File: doc/BRIEF.md
# Real-time counter with match wakeup

This block keeps time from a slow free-running clock. A 7-bit prescaler divides the input clock by 128 and produces one advance tick per period. The tick moves a 40-bit counter that software can load one byte at a time. A 40-bit match register is compared with the counter bit by bit. The result drives `match_o`, which a power controller can use as a wakeup request. The request can be one-shot, with the counter running past the match value. It can also be periodic, with the counter clearing itself on the match.

Software reaches every register through a byte-wide synchronous port. An access is one cycle: `bus_en_i` is high, `bus_we_i` selects write, `bus_addr_i` selects the register and, on a read, `bus_rdata_o` carries the combinational result. The counter moves while software reads it byte by byte. To keep such a read coherent, a read of the low counter byte copies the whole counter into a snapshot register, and the four upper counter bytes are read from that snapshot. The block makes no assumption about the input frequency: it counts prescaled ticks and nothing else.

Top module: `rtc_match_timer`

## Requirements
- R1: The prescaler free-runs from reset and is never disturbed by register writes. When counting is enabled, the counter advances on every rising edge whose number since reset release is a multiple of 128 (the first is edge 128).
- R2: After reset the counter, the match register and both control bits are zero, `match_o` is 1, and a read of address 10 returns 0x80.
- R3: `match_o` is 1 exactly when all 40 counter bits equal the match register bits. Bit 7 of a read of address 10 shows the same value.
- R4: Control bit 0 (address 10) enables counting. While it is 0 the counter holds its value, and setting it again resumes from that value.
- R5: When control bit 1 is 1 and a tick finds the counter nonzero and equal to the match register, the counter becomes zero instead of advancing.
- R6: A tick that finds the counter at zero always advances it to one, even when the match register is zero and self-clear is on.
- R7: With self-clear off, the counter counts past the match value and wraps from all ones to zero.
- R8: Address map: 0 to 4 hold counter bytes, least significant first. 5 to 9 hold match bytes, least significant first. 10 holds control. A write changes only the addressed byte. Addresses 11 to 15 read as 0 and ignore writes. Control bits 2 to 6 read as 0, and bit 7 ignores writes.
- R9: A read of address 0 returns the live low counter byte and copies the whole counter into the snapshot. Reads of addresses 1 to 4 return snapshot bytes 1 to 4, not the live counter.
- R10: A write to a counter byte on a tick edge wins: that byte takes the written value, the other counter bytes keep their values, and no advance happens on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timekeeping clock (slow crystal domain) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_en_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the cycle of the access |
| match_o | output | 1 | High while counter equals match register |

## Verification
The register map is exercised by a table of reads and writes made while counting is stopped. These show reset values, byte isolation, reserved bits and ignored addresses without any interference from time. Counting is then tried from several starting points: from zero against a distant match, and up to a nonzero match with self-clear on and off. It is also tried from zero against a zero match, and from all ones. This separates a clear-on-match from a plain increment, from the zero exception and from a wrap. The tick edge is located exactly by counting clocks from reset, and a counter write is placed on that very edge. A snapshot read is followed by a live write, so stale data and live data cannot be confused.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    // Control register bit positions (decoded by the register block).
    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_SCLR_BIT  = 1;
    localparam int CTRL_MATCH_BIT = 7;

    typedef struct packed {
        logic sclr;
        logic en;
    } rtc_ctrl_t;

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRESC_W = 7
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
    } presc_st_t;

    presc_st_t st_d, st_q;

    // One tick on the last state of each period of 2**PRESC_W clocks.
    assign tick_o = (st_q.presc == {PRESC_W{1'b1}});

    always_comb begin
        st_d       = st_q;
        st_d.presc = st_q.presc + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R1: the divider never skips or stalls
    a_r1_presc_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_o |=> st_q.presc == PRESC_W'($past(st_q.presc) + 1'b1));

    // R1: ticks are isolated single-cycle pulses
    a_r1_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
    parameter int CNT_W = 40,
    localparam int NB   = CNT_W / 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic             sclr_i,
    input  logic [NB-1:0]    cnt_wr_i,
    input  logic [NB-1:0]    match_wr_i,
    input  logic [7:0]       wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] mval_o,
    output logic             match_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] mval;
    } core_st_t;

    core_st_t         st_d, st_q;
    logic [CNT_W-1:0] eq_bits;
    logic             cnt_zero;
    logic             any_cnt_wr;

    // Per-bit equality, reduced by AND into the match flag.
    for (genvar gi = 0; gi < CNT_W; gi++) begin : g_eq
        assign eq_bits[gi] = ~(st_q.cnt[gi] ^ st_q.mval[gi]);
    end

    assign match_o    = &eq_bits;
    assign cnt_zero   = (st_q.cnt == '0);
    assign any_cnt_wr = |cnt_wr_i;
    assign cnt_o      = st_q.cnt;
    assign mval_o     = st_q.mval;

    always_comb begin
        st_d = st_q;
        // Advance; suppressed entirely by a counter byte write.
        if (tick_i && en_i && !any_cnt_wr) begin
            if (sclr_i && match_o && !cnt_zero) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        for (int b = 0; b < NB; b++) begin
            if (cnt_wr_i[b]) begin
                st_d.cnt[b*8 +: 8] = wdata_i;
            end
            if (match_wr_i[b]) begin
                st_d.mval[b*8 +: 8] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: no enable, no write -> counter holds
    a_r4_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !any_cnt_wr) |=> $stable(st_q.cnt));

    // R1: no tick, no write -> counter holds
    a_r1_only_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !any_cnt_wr) |=> $stable(st_q.cnt));

    // R5: clear on a nonzero match
    a_r5_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && en_i && sclr_i && match_o && !cnt_zero && !any_cnt_wr)
        |=> st_q.cnt == '0);

    // R6: zero always moves to one
    a_r6_zero_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && en_i && cnt_zero && !any_cnt_wr) |=> st_q.cnt == CNT_W'(1));

    // R7: wrap from all ones without self-clear
    a_r7_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && en_i && !sclr_i && (st_q.cnt == '1) && !any_cnt_wr)
        |=> st_q.cnt == '0);

    // R10: a low-byte write lands regardless of a tick
    a_r10_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_wr_i[0] |=> st_q.cnt[7:0] == $past(wdata_i));

endmodule

// File: rtl/rtc_bus_regs.sv
module rtc_bus_regs
    import rtc_pkg::*;
#(
    parameter int CNT_W  = 40,
    parameter int ADDR_W = 4,
    localparam int NB        = CNT_W / 8,
    localparam int CTRL_ADDR = 2 * NB
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_en_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CNT_W-1:0]  mval_i,
    input  logic              match_i,
    output logic [NB-1:0]     cnt_wr_o,
    output logic [NB-1:0]     match_wr_o,
    output logic              en_o,
    output logic              sclr_o
);

    typedef struct packed {
        logic [CNT_W-1:0] hold;
        rtc_ctrl_t        ctrl;
    } regs_st_t;

    regs_st_t st_d, st_q;
    logic     rd_acc;
    logic     wr_acc;
    logic     capture;
    int       addr_n;

    assign rd_acc  = bus_en_i && !bus_we_i;
    assign wr_acc  = bus_en_i && bus_we_i;
    assign addr_n  = int'(bus_addr_i);
    assign capture = rd_acc && (addr_n == 0);
    assign en_o    = st_q.ctrl.en;
    assign sclr_o  = st_q.ctrl.sclr;

    // Write decode and register update.
    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NB; b++) begin
            cnt_wr_o[b]   = wr_acc && (addr_n == b);
            match_wr_o[b] = wr_acc && (addr_n == NB + b);
        end
        if (wr_acc && (addr_n == CTRL_ADDR)) begin
            st_d.ctrl.en   = bus_wdata_i[CTRL_EN_BIT];
            st_d.ctrl.sclr = bus_wdata_i[CTRL_SCLR_BIT];
        end
        if (capture) begin
            st_d.hold = cnt_i;
        end
    end

    // Read mux: live low byte, snapshot upper bytes, match bytes, control.
    always_comb begin
        bus_rdata_o = '0;
        if (addr_n == 0) begin
            bus_rdata_o = cnt_i[7:0];
        end
        for (int b = 1; b < NB; b++) begin
            if (addr_n == b) begin
                bus_rdata_o = st_q.hold[b*8 +: 8];
            end
        end
        for (int b = 0; b < NB; b++) begin
            if (addr_n == NB + b) begin
                bus_rdata_o = mval_i[b*8 +: 8];
            end
        end
        if (addr_n == CTRL_ADDR) begin
            bus_rdata_o[CTRL_EN_BIT]    = st_q.ctrl.en;
            bus_rdata_o[CTRL_SCLR_BIT]  = st_q.ctrl.sclr;
            bus_rdata_o[CTRL_MATCH_BIT] = match_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: the snapshot only changes on a low-byte read
    a_r9_hold_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !capture |=> $stable(st_q.hold));

    // R9: a low-byte read stores the counter seen at that edge
    a_r9_hold_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        capture |=> st_q.hold == $past(cnt_i));

    // R8: unmapped addresses read as zero
    a_r8_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_acc && (addr_n > CTRL_ADDR)) |-> bus_rdata_o == 8'h00);

    // R8: at most one byte strobe per access
    a_r8_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({cnt_wr_o, match_wr_o}));

endmodule

// File: rtl/rtc_match_timer.sv
module rtc_match_timer #(
    parameter int CNT_W   = 40,
    parameter int PRESC_W = 7,
    parameter int ADDR_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_en_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    output logic              match_o
);

    // CNT_W must be a multiple of 8 and ADDR_W must reach 2*NB.
    localparam int NB = CNT_W / 8;

    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mval;
    logic [NB-1:0]    cnt_wr;
    logic [NB-1:0]    match_wr;
    logic             en;
    logic             sclr;

    rtc_prescaler #(
        .PRESC_W (PRESC_W)
    ) i_presc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    rtc_count_core #(
        .CNT_W (CNT_W)
    ) i_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .en_i       (en),
        .sclr_i     (sclr),
        .cnt_wr_i   (cnt_wr),
        .match_wr_i (match_wr),
        .wdata_i    (bus_wdata_i),
        .cnt_o      (cnt),
        .mval_o     (mval),
        .match_o    (match_o)
    );

    rtc_bus_regs #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) i_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bus_en_i    (bus_en_i),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .cnt_i       (cnt),
        .mval_i      (mval),
        .match_i     (match_o),
        .cnt_wr_o    (cnt_wr),
        .match_wr_o  (match_wr),
        .en_o        (en),
        .sclr_o      (sclr)
    );

endmodule

// File: tb/test_rtc_match_timer.sv
module test_rtc_match_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       match;

    int checks = 0;
    int errors = 0;
    logic [31:0] cyc;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // Rising edges since reset release; the tick edges are multiples of 128.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= cyc + 1;
    end

    rtc_match_timer i_rtc_match_timer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_en_i    (bus_en),
        .bus_we_i    (bus_we),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .match_o     (match)
    );

    // Vector: {we, addr, wdata, expected read data}
    localparam int NV = 18;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 4'd10, 8'h00, 8'h80},   // R2 reset control, match high
        {1'b0, 4'd0,  8'h00, 8'h00},   // R2 counter low
        {1'b0, 4'd4,  8'h00, 8'h00},   // R2 counter high
        {1'b0, 4'd5,  8'h00, 8'h00},   // R2 match low
        {1'b0, 4'd9,  8'h00, 8'h00},   // R2 match high
        {1'b1, 4'd5,  8'h3C, 8'h00},
        {1'b0, 4'd5,  8'h00, 8'h3C},   // R8 readback
        {1'b0, 4'd10, 8'h00, 8'h00},   // R3 match dropped
        {1'b1, 4'd9,  8'hA5, 8'h00},
        {1'b0, 4'd9,  8'h00, 8'hA5},   // R8 readback
        {1'b0, 4'd6,  8'h00, 8'h00},   // R8 neighbour untouched
        {1'b1, 4'd10, 8'hFE, 8'h00},
        {1'b0, 4'd10, 8'h00, 8'h02},   // R8 reserved bits and bit 7 ignored
        {1'b1, 4'd12, 8'hFF, 8'h00},
        {1'b0, 4'd12, 8'h00, 8'h00},   // R8 unmapped reads zero
        {1'b0, 4'd9,  8'h00, 8'hA5},   // R8 unmapped write ignored
        {1'b1, 4'd10, 8'h00, 8'h00},
        {1'b0, 4'd10, 8'h00, 8'h00}    // R8 control cleared
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Bus operations start and end at a falling edge, one rising edge each.
    task automatic bus_op(input logic we, input logic [3:0] a, input logic [7:0] d,
                          output logic [7:0] rd);
        bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        #1 rd = bus_rdata;
        @(posedge clk);
        #1 bus_en = 1'b0; bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        logic [7:0] rd;
        bus_op(1'b1, a, d, rd);
    endtask

    task automatic rd8(input logic [3:0] a, output logic [7:0] v);
        bus_op(1'b0, a, 8'h00, v);
    endtask

    task automatic load_cnt(input logic [39:0] v);
        for (int b = 0; b < 5; b++) wr(4'(b), v[b*8 +: 8]);
    endtask

    task automatic load_match(input logic [39:0] v);
        for (int b = 0; b < 5; b++) wr(4'(5 + b), v[b*8 +: 8]);
    endtask

    task automatic read_cnt(output logic [39:0] v);
        for (int b = 0; b < 5; b++) begin
            logic [7:0] t;
            rd8(4'(b), t);
            v[b*8 +: 8] = t;
        end
    endtask

    task automatic align(input int phase);
        while ((cyc % 128) != phase) @(negedge clk);
    endtask

    // Enable counting for exactly n tick edges, then stop.
    task automatic run_ticks(input int n, input logic sclr);
        align(2);
        wr(4'd10, {6'b0, sclr, 1'b1});
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            align(2);
        end
        wr(4'd10, {6'b0, sclr, 1'b0});
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b8;
        logic [39:0] c40;

        repeat (3) @(negedge clk);
        check("R2 match after reset", match, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        // Register map walk while counting is stopped.
        for (int i = 0; i < NV; i++) begin
            rd8(4'd0, b8); // keep phase simple: dummy read not checked
            bus_op(VEC[i][20], VEC[i][19:16], VEC[i][15:8], b8);
            if (!VEC[i][20]) check($sformatf("R2/R3/R8 table row %0d", i), b8, VEC[i][7:0]);
        end

        // R1: exact tick edge.
        align(120);
        wr(4'd10, 8'h01);
        align(127);
        rd8(4'd0, b8);
        check("R1 before tick edge", b8, 8'h00);
        rd8(4'd0, b8);
        check("R1 after tick edge", b8, 8'h01);
        wr(4'd10, 8'h00);

        // R4: frozen while disabled, resumes from held value.
        load_cnt(40'd7);
        repeat (300) @(negedge clk);
        read_cnt(c40);
        check("R4 frozen", c40, 40'd7);
        run_ticks(2, 1'b0);
        read_cnt(c40);
        check("R4 resumed", c40, 40'd9);

        // R3 / R5: count to a nonzero match with self-clear.
        load_match(40'd3);
        load_cnt(40'd0);
        run_ticks(3, 1'b1);
        read_cnt(c40);
        check("R5 reached match", c40, 40'd3);
        check("R3 match high", match, 1'b1);
        rd8(4'd10, b8);
        check("R3 status bit 7", b8, 8'h82);
        run_ticks(1, 1'b1);
        read_cnt(c40);
        check("R5 cleared", c40, 40'd0);
        check("R3 match low after clear", match, 1'b0);

        // R3: single differing top bit.
        load_cnt(40'h80_0000_0003);
        check("R3 bit 39 differs", match, 1'b0);

        // R6: zero against zero advances.
        load_match(40'd0);
        load_cnt(40'd0);
        check("R6 match at zero", match, 1'b1);
        run_ticks(1, 1'b1);
        read_cnt(c40);
        check("R6 zero advanced", c40, 40'd1);

        // R7: count past match, then wrap.
        load_match(40'd2);
        load_cnt(40'd0);
        run_ticks(3, 1'b0);
        read_cnt(c40);
        check("R7 passed match", c40, 40'd3);
        load_match(40'd5);
        load_cnt(40'hFF_FFFF_FFFF);
        run_ticks(2, 1'b0);
        read_cnt(c40);
        check("R7 wrap", c40, 40'd1);

        // R10: write on the tick edge wins.
        load_cnt(40'h00_0000_0110);
        align(2);
        wr(4'd10, 8'h01);
        align(127);
        wr(4'd0, 8'h55);
        wr(4'd10, 8'h00);
        read_cnt(c40);
        check("R10 write beats tick", c40, 40'h00_0000_0155);

        // R9: snapshot coherence.
        load_cnt(40'h0A_0B0C_0D0E);
        rd8(4'd0, b8);
        check("R9 live low byte", b8, 8'h0E);
        wr(4'd2, 8'hFF);
        rd8(4'd2, b8);
        check("R9 snapshot byte", b8, 8'h0C);
        rd8(4'd0, b8);
        rd8(4'd2, b8);
        check("R9 refreshed snapshot", b8, 8'hFF);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule